// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Per-Pin Interrupt Typing

The block is a general-purpose I/O controller for sixteen pins. Software uses a simple word-addressed register port to set output values and pin directions, read the pin inputs, and pick how each pin raises an interrupt. The block has no pad drivers, no pin multiplexing and no clock outputs. It drives output values and active-high output enables towards the pads. Every pin has its own interrupt line, and that line carries the pin's status bit.

Before use, each input passes through a two-flop synchroniser. A per-pin detector compares the synchronised sample with the sample taken one cycle earlier. The detector's mode is a 3-bit code with these states:

- `MODE_HIGH`: level high.
- `MODE_LOW`: level low.
- `MODE_RISE`: rising edge.
- `MODE_FALL`: falling edge.
- `MODE_ANY`: any transition.
- `MODE_RSV5`, `MODE_RSV6`, `MODE_RSV7`: quiet, never raise an event.

A status bit has two transitions. It goes from clear to set when its detector reports an event. It goes from set to clear when software writes a 1 to that bit and no new event arrives in the same cycle.

Top module: `gpio_typed_irq`

## Requirements
- R1: After reset, the pin outputs are 0 and the output enables are 0, because every direction bit resets to 1. The interrupt status and both type registers read 0.
- R2: Offset 0x00 holds the output data and drives `pin_out`. In the direction register at offset 0x04, a 1 makes a pin an input and a 0 makes it an output. `pin_oe` is the inverse of the direction register. Both registers read back what was written.
- R3: Offset 0x08 returns `pin_in` after a two-flop synchroniser, for all pins whatever their direction. A new value reads back after the second rising edge. Writes to this offset have no effect.
- R4: Each pin's 3-bit type code sits at bits 3*(p mod 8)+2 : 3*(p mod 8). Pins 0 to 7 use the register at offset 0x10, and pins 8 to 15 use the register at offset 0x14. Bits 31:24 of both registers read 0.
- R5: Code 0 (high level) and code 1 (low level) set the status bit on every cycle the level is present. A bit cleared while its level persists therefore sets again.
- R6: Code 2 (rising edge), code 3 (falling edge) and code 4 (any transition) set the status bit once per synchronised transition. The bit then stays set until it is cleared.
- R7: The status register at offset 0x0C is cleared by writing 1s. Writing 0 to a bit leaves it unchanged. An event detected in the same cycle as a clear wins, so the bit stays set.
- R8: Codes 5, 6 and 7 never set a status bit.
- R9: A pin whose direction bit is 0 (output) never sets its status bit.
- R10: `pin_irq` equals the status register. A pin change becomes visible there after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| pin_in | input | 16 | Pin input values from the pads |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Output enable, 1 = drive |
| pin_irq | output | 16 | One interrupt line per pin |

## Verification
The assertions assume the following about the inputs:

- `pin_in` is low while reset is applied and for the first cycles after it, so that the previous-sample flops start equal to the synchronised input.
- A write and its data are stable around the rising edge.

The stimulus keeps within these assumptions in three ways:

- It drives every input only at falling edges.
- It holds the pins low until the first configuration is written.
- Before each sweep step it parks every pin in a quiet mode and clears the status, so no leftover edge leaks into the next step.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    typedef enum logic [2:0] {
        MODE_HIGH = 3'd0,
        MODE_LOW  = 3'd1,
        MODE_RISE = 3'd2,
        MODE_FALL = 3'd3,
        MODE_ANY  = 3'd4,
        MODE_RSV5 = 3'd5,
        MODE_RSV6 = 3'd6,
        MODE_RSV7 = 3'd7
    } trig_mode_e;

    localparam int MODE_W        = 3;
    localparam int PINS_PER_TREG = 8;
    localparam int OFF_DOUT      = 'h00;
    localparam int OFF_DIR       = 'h04;
    localparam int OFF_DIN       = 'h08;
    localparam int OFF_STAT      = 'h0C;
    localparam int OFF_TYPE0     = 'h10;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_i,
    input  logic       enable_i,
    input  trig_mode_e mode_i,
    input  logic       clr_i,
    output logic       status_o
);
    logic prev_q;
    logic status_q;
    logic raw_hit;
    logic hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sample_i;
    end

    always_comb begin
        raw_hit = 1'b0;
        unique case (mode_i)
            MODE_HIGH: raw_hit = sample_i;
            MODE_LOW:  raw_hit = ~sample_i;
            MODE_RISE: raw_hit = sample_i & ~prev_q;
            MODE_FALL: raw_hit = ~sample_i & prev_q;
            MODE_ANY:  raw_hit = sample_i ^ prev_q;
            MODE_RSV5, MODE_RSV6, MODE_RSV7: raw_hit = 1'b0;
        endcase
        hit = raw_hit & enable_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= 1'b0;
        else        status_q <= (status_q & ~clr_i) | hit;
    end

    assign status_o = status_q;

    p_hit_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> status_o);
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !status_o);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !clr_i) |=> status_o);
    p_rsv_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i inside {MODE_RSV5, MODE_RSV6, MODE_RSV7}) && !status_o) |=> !status_o);
    p_out_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !status_o) |=> !status_o);
endmodule

// File: rtl/gpio_typed_irq.sv
module gpio_typed_irq
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_irq
);
    localparam int NUM_TREGS = (NUM_PINS + PINS_PER_TREG - 1) / PINS_PER_TREG;
    localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFF_DOUT);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFF_DIN);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

    logic [NUM_PINS-1:0]             dout_q;
    logic [NUM_PINS-1:0]             dir_q;
    logic [NUM_PINS-1:0]             din_sync;
    logic [NUM_PINS-1:0]             stat_w;
    logic [NUM_PINS-1:0]             stat_clr;
    logic [NUM_PINS-1:0][MODE_W-1:0] mode_flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '1;
        end else if (reg_we) begin
            if (reg_addr == A_DOUT) dout_q <= reg_wdata[NUM_PINS-1:0];
            if (reg_addr == A_DIR)  dir_q  <= reg_wdata[NUM_PINS-1:0];
        end
    end

    assign stat_clr = (reg_we && reg_addr == A_STAT) ? reg_wdata[NUM_PINS-1:0] : '0;

    gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (din_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int TREG = p / PINS_PER_TREG;
        localparam int SLOT = p % PINS_PER_TREG;
        localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(OFF_TYPE0 + 4 * TREG);
        trig_mode_e mode_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mode_q <= MODE_HIGH;
            else if (reg_we && reg_addr == A_TYPE)
                mode_q <= trig_mode_e'(reg_wdata[MODE_W*SLOT +: MODE_W]);
        end

        assign mode_flat[p] = mode_q;

        gpio_event_det u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .sample_i(din_sync[p]),
            .enable_i(dir_q[p]),
            .mode_i  (mode_q),
            .clr_i   (stat_clr[p]),
            .status_o(stat_w[p])
        );
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DOUT:  reg_rdata[NUM_PINS-1:0] = dout_q;
            A_DIR:   reg_rdata[NUM_PINS-1:0] = dir_q;
            A_DIN:   reg_rdata[NUM_PINS-1:0] = din_sync;
            A_STAT:  reg_rdata[NUM_PINS-1:0] = stat_w;
            default: reg_rdata = '0;
        endcase
        for (int k = 0; k < NUM_TREGS; k++) begin
            if (reg_addr == ADDR_W'(OFF_TYPE0 + 4 * k)) begin
                for (int j = 0; j < PINS_PER_TREG; j++) begin
                    if (k * PINS_PER_TREG + j < NUM_PINS)
                        reg_rdata[MODE_W*j +: MODE_W] = mode_flat[k * PINS_PER_TREG + j];
                end
            end
        end
    end

    assign pin_out = dout_q;
    assign pin_oe  = ~dir_q;
    assign pin_irq = stat_w;

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_DIR) |=> (pin_oe == ~$past(reg_wdata[NUM_PINS-1:0])));
    p_dout_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_DOUT) |=> (pin_out == $past(reg_wdata[NUM_PINS-1:0])));
    p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we || reg_addr != A_STAT) |=> ((pin_irq & $past(pin_irq)) == $past(pin_irq)));
endmodule

// File: tb/test_gpio_typed_irq.sv
module test_gpio_typed_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [15:0] pin_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gpio_typed_irq i_gpio_typed_irq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_irq(pin_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] type_word(input int k, input int pin, input int m);
        logic [31:0] w = '0;
        for (int j = 0; j < 8; j++)
            w[3*j +: 3] = ((k * 8 + j) == pin) ? 3'(m) : 3'd7;
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] bitv;
        logic [15:0] e_pre, e_rise, e_clr, e_fall;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 pin_out", 32'(pin_out), 32'h0);
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 pin_irq", 32'(pin_irq), 32'h0);
        rd(8'h04, v); check("R1 dir", v, 32'h0000FFFF);
        rd(8'h10, v); check("R1 type0", v, 32'h0);
        rd(8'h14, v); check("R1 type1", v, 32'h0);
        rd(8'h0C, v); check("R1 status", v, 32'h0);

        // R2 output data and direction
        wr(8'h00, 32'h0000A5C3);
        check("R2 pin_out", 32'(pin_out), 32'hA5C3);
        rd(8'h00, v); check("R2 dout readback", v, 32'hA5C3);

        // Near-exhaustive sweep over pin x mode
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 8; m++) begin
                bitv = 16'(1) << p;
                pin_in = '0;
                wr(8'h10, 32'h00FFFFFF);
                wr(8'h14, 32'h00FFFFFF);
                tick(3);
                wr(8'h0C, 32'hFFFF);
                rd(8'h0C, v); check("R8 quiet baseline", v, 32'h0);
                e_pre  = (m == 1) ? bitv : 16'h0;
                e_rise = (m == 0 || m == 1 || m == 2 || m == 4) ? bitv : 16'h0;
                e_clr  = (m == 0) ? bitv : 16'h0;
                e_fall = (m == 0 || m == 1 || m == 3 || m == 4) ? bitv : 16'h0;
                wr(8'h10 + 8'(4 * (p / 8)), type_word(p / 8, p, m));
                wr(8'h0C, 32'hFFFF);
                rd(8'h0C, v); check("R7 clear vs level R5", v, 32'(e_pre));
                rd(8'h10 + 8'(4 * (p / 8)), v);
                check("R4 type packing", v, type_word(p / 8, p, m));
                pin_in = bitv;
                tick(2);
                check("R10 latency not yet", 32'(pin_irq), 32'(e_pre));
                tick(1);
                rd(8'h0C, v); check("R6 R5 R8 after rise", v, 32'(e_rise));
                check("R10 irq mirror", 32'(pin_irq), 32'(e_rise));
                rd(8'h08, v); check("R3 input sync", v, 32'(bitv));
                wr(8'h0C, 32'hFFFF);
                rd(8'h0C, v); check("R5 reassert R7 clear", v, 32'(e_clr));
                pin_in = '0;
                tick(3);
                rd(8'h0C, v); check("R6 R5 after fall", v, 32'(e_fall));
                check("R10 irq mirror fall", 32'(pin_irq), 32'(e_fall));
            end
        end

        // R9 direction: outputs never raise status
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h0);
        wr(8'h04, 32'h0000FF00);
        check("R2 pin_oe", 32'(pin_oe), 32'h00FF);
        rd(8'h04, v); check("R2 dir readback", v, 32'hFF00);
        wr(8'h0C, 32'hFFFF);
        pin_in = 16'hFFFF;
        tick(3);
        rd(8'h0C, v); check("R9 outputs quiet", v, 32'hFF00);
        rd(8'h08, v); check("R3 input all pins", v, 32'hFFFF);
        wr(8'h08, 32'h00001234);
        rd(8'h08, v); check("R3 write ignored", v, 32'hFFFF);
        wr(8'h0C, 32'h0);
        rd(8'h0C, v); check("R7 zero write no effect", v, 32'hFF00);
        rd(8'h10, v); check("R4 upper bits zero", v & 32'hFF000000, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule